// File: doc/BRIEF.md
# Conversion Status and Event Flag Unit

This block holds the status and event flags of one filter inside a sigma-delta acquisition front end. Two conversion paths feed it: a regular path and an injected path. Each path reports when a conversion completes, when its result register is read, and when software or a trigger asks for a new conversion. From these events the unit keeps an end-of-conversion flag, an overrun flag and a busy flag for each path. It also produces a load enable for the path's result register. That enable is withheld when a completion would overwrite an unread result.

The unit also keeps per-channel threshold-crossing source flags and one watchdog summary flag built from them. It keeps per-channel clock-absent and short-circuit flags, which follow each channel's enable and synchronisation state. Each flag has its own way of clearing:
- by reading the data,
- by a write-one-to-clear strobe,
- by hardware,
- by clearing every source flag behind a summary.

A registered interrupt line merges the enabled flags.

Top module: `conv_flag_unit`

## Requirements
- R1: While reset is asserted, every flag output, every source flag and `irq` read 0.
- R2: A completion pulse sets the path's end-of-conversion flag in the next cycle. A data-read strobe clears it in the next cycle. A completion in the same cycle as a read leaves the flag at 1.
- R3: A completion while the end-of-conversion flag is 1, and with no read in that cycle, sets the overrun flag in the next cycle and holds the load enable at 0 in that cycle. Every other completion raises the load enable in the same cycle.
- R4: An overrun flag clears only through its own clear strobe. A data read leaves it at 1. A new overrun in the same cycle as the clear strobe leaves it at 1. The two paths are independent.
- R5: A software or trigger start while the path is idle sets the busy flag in the next cycle. A completion clears it. A start that arrives while busy is dropped, so busy falls after the completion even if a start came in the same cycle.
- R6: Each high-threshold and low-threshold source bit is set by its event pulse and cleared by its own clear strobe. An event in the same cycle as the clear wins. The watchdog flag is 1 whenever any source bit is 1, and it falls only after all of them are cleared.
- R7: A clock-absent bit is forced to 1 while its channel is disabled or not synchronised. On an enabled, synchronised channel, the bit is set by a detection pulse and cleared by its clear strobe, and a detection wins over a clear in the same cycle.
- R8: A short-circuit bit is set by a detection pulse and cleared by its clear strobe, and a detection wins over a clear in the same cycle. While the channel is disabled, the bit is held at 0, even when a detection pulse arrives.
- R9: `irq` is 1 one cycle after any flag ANDed with its enable bit is 1. The `irq_en` bit order is:
  - 0: injected end-of-conversion
  - 1: regular end-of-conversion
  - 2: injected overrun
  - 3: regular overrun
  - 4: watchdog
  - 5: any clock-absent bit
  - 6: any short-circuit bit

  With `irq_en` at 0, `irq` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_start_sw | input | 1 | Software start, regular path |
| reg_start_trig | input | 1 | Trigger start, regular path |
| reg_done | input | 1 | Regular conversion complete pulse |
| reg_data_rd | input | 1 | Regular result register read strobe |
| clr_reg_ovr | input | 1 | Clear strobe, regular overrun |
| inj_start_sw | input | 1 | Software start, injected path |
| inj_start_trig | input | 1 | Trigger start, injected path |
| inj_done | input | 1 | Injected conversion complete pulse |
| inj_data_rd | input | 1 | Injected result register read strobe |
| clr_inj_ovr | input | 1 | Clear strobe, injected overrun |
| awd_hi_set | input | NCH | High-threshold crossing pulses |
| awd_lo_set | input | NCH | Low-threshold crossing pulses |
| clr_awd_hi | input | NCH | Clear strobes, high-threshold sources |
| clr_awd_lo | input | NCH | Clear strobes, low-threshold sources |
| chan_en | input | NCH | Channel enable bits |
| chan_sync | input | NCH | Channel receiver synchronised |
| clk_miss_det | input | NCH | Clock-absence detection pulses |
| short_det | input | NCH | Short-circuit limit reached pulses |
| clr_clk_miss | input | NCH | Clear strobes, clock-absent bits |
| clr_short | input | NCH | Clear strobes, short-circuit bits |
| irq_en | input | 7 | Interrupt enable per flag group |
| reg_load_en | output | 1 | Regular result register load enable |
| inj_load_en | output | 1 | Injected result register load enable |
| reg_eoc | output | 1 | Regular end-of-conversion flag |
| inj_eoc | output | 1 | Injected end-of-conversion flag |
| reg_ovr | output | 1 | Regular overrun flag |
| inj_ovr | output | 1 | Injected overrun flag |
| reg_busy | output | 1 | Regular conversion in progress |
| inj_busy | output | 1 | Injected conversion in progress |
| awd_hi_src | output | NCH | High-threshold source flags |
| awd_lo_src | output | NCH | Low-threshold source flags |
| awd_flag | output | 1 | Watchdog summary flag |
| clk_miss_flag | output | NCH | Clock-absent flags |
| short_flag | output | NCH | Short-circuit flags |
| irq | output | 1 | Registered interrupt request |

## Verification
Every flag is a single register fed directly by its events, so a wrong state shows at its port one cycle after the stimulus, and at `irq` one cycle later. A wrong end-of-conversion state shows at once on the combinational load enable of the next completion, because it either drops a valid result or lets an unread one be overwritten. A busy flag stuck high shows as a start that never takes effect. A summary flag that falls too early shows on `awd_flag` while one source bit is still set.

// File: rtl/conv_flag_pkg.sv
package conv_flag_pkg;

  localparam int unsigned IRQ_W       = 7;
  localparam int unsigned IRQ_INJ_EOC = 0;
  localparam int unsigned IRQ_REG_EOC = 1;
  localparam int unsigned IRQ_INJ_OVR = 2;
  localparam int unsigned IRQ_REG_OVR = 3;
  localparam int unsigned IRQ_AWD     = 4;
  localparam int unsigned IRQ_CKM     = 5;
  localparam int unsigned IRQ_SCD     = 6;

  // a completion overwrites an unread result unless the read lands in the same cycle
  function automatic logic path_overrun(logic done, logic eoc, logic rd);
    return done & eoc & ~rd;
  endfunction

  // sticky bit: set wins over clear
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // clock-absent bit: forced while channel not usable
  function automatic logic ckm_next(logic cur, logic en, logic sync, logic det, logic clr);
    return (~en | ~sync) ? 1'b1 : sticky_next(cur, det, clr);
  endfunction

  // short-circuit bit: held clear while channel disabled
  function automatic logic scd_next(logic cur, logic en, logic det, logic clr);
    return en ? sticky_next(cur, det, clr) : 1'b0;
  endfunction

endpackage

// File: rtl/conv_path_status.sv
module conv_path_status
  import conv_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_sw,
  input  logic start_trig,
  input  logic conv_done,
  input  logic data_rd,
  input  logic ovr_clr,
  output logic eoc,
  output logic ovr,
  output logic busy,
  output logic load_en
);

  logic eoc_q, ovr_q, busy_q;
  logic start_req, start_acc, ovr_evt;

  assign start_req = start_sw | start_trig;
  assign start_acc = start_req & ~busy_q;
  assign ovr_evt   = path_overrun(conv_done, eoc_q, data_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoc_q  <= 1'b0;
      ovr_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      eoc_q  <= sticky_next(eoc_q, conv_done, data_rd);
      ovr_q  <= sticky_next(ovr_q, ovr_evt, ovr_clr);
      if (conv_done)      busy_q <= 1'b0;
      else if (start_acc) busy_q <= 1'b1;
    end
  end

  assign eoc     = eoc_q;
  assign ovr     = ovr_q;
  assign busy    = busy_q;
  assign load_en = conv_done & ~ovr_evt;

  assert_eoc_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> eoc_q);
  assert_load_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (!eoc_q || data_rd));
  assert_ovr_raised_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && eoc_q && !data_rd) |=> ovr_q);
  assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q);
  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !conv_done) |=> busy_q);
  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !busy_q);

endmodule

// File: rtl/conv_awd_summary.sv
module conv_awd_summary
  import conv_flag_pkg::*;
#(
  parameter int unsigned NCH = 8
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hi_set,
  input  logic [NCH-1:0] lo_set,
  input  logic [NCH-1:0] hi_clr,
  input  logic [NCH-1:0] lo_clr,
  output logic [NCH-1:0] hi_src,
  output logic [NCH-1:0] lo_src,
  output logic           awd
);

  logic [NCH-1:0] hi_q, lo_q;

  for (genvar g = 0; g < NCH; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q[g] <= 1'b0;
        lo_q[g] <= 1'b0;
      end else begin
        hi_q[g] <= sticky_next(hi_q[g], hi_set[g], hi_clr[g]);
        lo_q[g] <= sticky_next(lo_q[g], lo_set[g], lo_clr[g]);
      end
    end
  end

  assign hi_src = hi_q;
  assign lo_src = lo_q;
  assign awd    = (|hi_q) | (|lo_q);

  assert_awd_on_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hi_set) || (|lo_set)) |=> awd);
  assert_awd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (awd && !(|hi_clr) && !(|lo_clr)) |=> awd);

endmodule

// File: rtl/conv_chan_flags.sv
module conv_chan_flags
  import conv_flag_pkg::*;
#(
  parameter int unsigned NCH = 8
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] chan_sync,
  input  logic [NCH-1:0] ckm_det,
  input  logic [NCH-1:0] scd_det,
  input  logic [NCH-1:0] ckm_clr,
  input  logic [NCH-1:0] scd_clr,
  output logic [NCH-1:0] ckm_flag,
  output logic [NCH-1:0] scd_flag
);

  logic [NCH-1:0] ckm_q, scd_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ckm_q[g] <= 1'b0;
        scd_q[g] <= 1'b0;
      end else begin
        ckm_q[g] <= ckm_next(ckm_q[g], chan_en[g], chan_sync[g], ckm_det[g], ckm_clr[g]);
        scd_q[g] <= scd_next(scd_q[g], chan_en[g], scd_det[g], scd_clr[g]);
      end
    end

    assert_ckm_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en[g] || !chan_sync[g]) |=> ckm_q[g]);
    assert_scd_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[g] |=> !scd_q[g]);
  end

  assign ckm_flag = ckm_q;
  assign scd_flag = scd_q;

endmodule

// File: rtl/conv_flag_unit.sv
module conv_flag_unit
  import conv_flag_pkg::*;
#(
  parameter int unsigned NCH = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_start_sw,
  input  logic             reg_start_trig,
  input  logic             reg_done,
  input  logic             reg_data_rd,
  input  logic             clr_reg_ovr,
  input  logic             inj_start_sw,
  input  logic             inj_start_trig,
  input  logic             inj_done,
  input  logic             inj_data_rd,
  input  logic             clr_inj_ovr,
  input  logic [NCH-1:0]   awd_hi_set,
  input  logic [NCH-1:0]   awd_lo_set,
  input  logic [NCH-1:0]   clr_awd_hi,
  input  logic [NCH-1:0]   clr_awd_lo,
  input  logic [NCH-1:0]   chan_en,
  input  logic [NCH-1:0]   chan_sync,
  input  logic [NCH-1:0]   clk_miss_det,
  input  logic [NCH-1:0]   short_det,
  input  logic [NCH-1:0]   clr_clk_miss,
  input  logic [NCH-1:0]   clr_short,
  input  logic [IRQ_W-1:0] irq_en,
  output logic             reg_load_en,
  output logic             inj_load_en,
  output logic             reg_eoc,
  output logic             inj_eoc,
  output logic             reg_ovr,
  output logic             inj_ovr,
  output logic             reg_busy,
  output logic             inj_busy,
  output logic [NCH-1:0]   awd_hi_src,
  output logic [NCH-1:0]   awd_lo_src,
  output logic             awd_flag,
  output logic [NCH-1:0]   clk_miss_flag,
  output logic [NCH-1:0]   short_flag,
  output logic             irq
);

  logic [IRQ_W-1:0] flag_vec;
  logic             irq_any;
  logic             irq_q;

  conv_path_status u_reg_path (
    .clk(clk), .rst_n(rst_n),
    .start_sw(reg_start_sw), .start_trig(reg_start_trig),
    .conv_done(reg_done), .data_rd(reg_data_rd), .ovr_clr(clr_reg_ovr),
    .eoc(reg_eoc), .ovr(reg_ovr), .busy(reg_busy), .load_en(reg_load_en)
  );

  conv_path_status u_inj_path (
    .clk(clk), .rst_n(rst_n),
    .start_sw(inj_start_sw), .start_trig(inj_start_trig),
    .conv_done(inj_done), .data_rd(inj_data_rd), .ovr_clr(clr_inj_ovr),
    .eoc(inj_eoc), .ovr(inj_ovr), .busy(inj_busy), .load_en(inj_load_en)
  );

  conv_awd_summary #(.NCH(NCH)) u_awd (
    .clk(clk), .rst_n(rst_n),
    .hi_set(awd_hi_set), .lo_set(awd_lo_set),
    .hi_clr(clr_awd_hi), .lo_clr(clr_awd_lo),
    .hi_src(awd_hi_src), .lo_src(awd_lo_src), .awd(awd_flag)
  );

  conv_chan_flags #(.NCH(NCH)) u_chan (
    .clk(clk), .rst_n(rst_n),
    .chan_en(chan_en), .chan_sync(chan_sync),
    .ckm_det(clk_miss_det), .scd_det(short_det),
    .ckm_clr(clr_clk_miss), .scd_clr(clr_short),
    .ckm_flag(clk_miss_flag), .scd_flag(short_flag)
  );

  always_comb begin
    flag_vec              = '0;
    flag_vec[IRQ_INJ_EOC] = inj_eoc;
    flag_vec[IRQ_REG_EOC] = reg_eoc;
    flag_vec[IRQ_INJ_OVR] = inj_ovr;
    flag_vec[IRQ_REG_OVR] = reg_ovr;
    flag_vec[IRQ_AWD]     = awd_flag;
    flag_vec[IRQ_CKM]     = |clk_miss_flag;
    flag_vec[IRQ_SCD]     = |short_flag;
  end

  assign irq_any = |(flag_vec & irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_any;
  end

  assign irq = irq_q;

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |=> !irq);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_eoc && irq_en[IRQ_REG_EOC]) |=> irq);
  assert_reset_clean_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq && !reg_eoc && !inj_eoc && !reg_busy && !inj_busy));

endmodule

// File: tb/conv_flag_unit_bench.sv
module conv_flag_unit_bench;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_start_sw, reg_start_trig, reg_done, reg_data_rd, clr_reg_ovr;
  logic inj_start_sw, inj_start_trig, inj_done, inj_data_rd, clr_inj_ovr;
  logic [NCH-1:0] awd_hi_set, awd_lo_set, clr_awd_hi, clr_awd_lo;
  logic [NCH-1:0] chan_en, chan_sync, clk_miss_det, short_det, clr_clk_miss, clr_short;
  logic [6:0] irq_en;
  logic reg_load_en, inj_load_en, reg_eoc, inj_eoc, reg_ovr, inj_ovr, reg_busy, inj_busy;
  logic [NCH-1:0] awd_hi_src, awd_lo_src, clk_miss_flag, short_flag;
  logic awd_flag, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  conv_flag_unit #(.NCH(NCH)) u_conv_flag_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    {reg_start_sw, reg_start_trig, reg_done, reg_data_rd, clr_reg_ovr} = '0;
    {inj_start_sw, inj_start_trig, inj_done, inj_data_rd, clr_inj_ovr} = '0;
    awd_hi_set = '0; awd_lo_set = '0; clr_awd_hi = '0; clr_awd_lo = '0;
    clk_miss_det = '0; short_det = '0; clr_clk_miss = '0; clr_short = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_inputs(); chan_en = '0; chan_sync = '0; irq_en = '1;
    step(); step();
    check("R1 flags in reset", {reg_eoc, inj_eoc, reg_ovr, inj_ovr, reg_busy, inj_busy, awd_flag, irq}, 0);
    check("R1 vectors in reset", {awd_hi_src, awd_lo_src, clk_miss_flag, short_flag}, 0);
    irq_en = '0; rst_n = 1'b1; step();
    check("R7 disabled forces clock-absent", clk_miss_flag, 8'hFF);
  endtask

  task automatic t_eoc();
    reg_done = 1; #1;
    check("R3 load on clean completion", reg_load_en, 1);
    step(); idle_inputs();
    check("R2 eoc set", reg_eoc, 1);
    reg_data_rd = 1; step(); idle_inputs();
    check("R2 eoc cleared by read", reg_eoc, 0);
    reg_done = 1; step(); idle_inputs();
    reg_done = 1; reg_data_rd = 1; #1;
    check("R3 load when read coincides", reg_load_en, 1);
    step(); idle_inputs();
    check("R2 completion beats read", {reg_eoc, reg_ovr}, 2'b10);
    reg_data_rd = 1; step(); idle_inputs();
    inj_done = 1; step(); idle_inputs();
    check("R2 injected eoc", {inj_eoc, reg_eoc}, 2'b10);
    inj_data_rd = 1; step(); idle_inputs();
    check("R2 injected eoc cleared", inj_eoc, 0);
  endtask

  task automatic t_overrun();
    reg_done = 1; step(); idle_inputs();
    reg_done = 1; #1;
    check("R3 load blocked on overrun", reg_load_en, 0);
    step(); idle_inputs();
    check("R3 overrun set", {reg_ovr, reg_eoc, inj_ovr}, 3'b110);
    reg_data_rd = 1; step(); idle_inputs();
    check("R4 read keeps overrun", {reg_ovr, reg_eoc}, 2'b10);
    clr_reg_ovr = 1; step(); idle_inputs();
    check("R4 clear strobe", reg_ovr, 0);
    reg_done = 1; step(); idle_inputs();
    reg_done = 1; clr_reg_ovr = 1; step(); idle_inputs();
    check("R4 overrun beats clear", reg_ovr, 1);
    clr_reg_ovr = 1; reg_data_rd = 1; step(); idle_inputs();
    inj_done = 1; step(); idle_inputs();
    inj_done = 1; #1;
    check("R3 injected load blocked", inj_load_en, 0);
    step(); idle_inputs();
    check("R4 paths independent", {inj_ovr, reg_ovr}, 2'b10);
    clr_inj_ovr = 1; inj_data_rd = 1; step(); idle_inputs();
    check("R4 injected clear", {inj_ovr, inj_eoc}, 2'b00);
  endtask

  task automatic t_busy();
    reg_start_sw = 1; step(); idle_inputs();
    check("R5 software start", reg_busy, 1);
    reg_start_trig = 1; step(); idle_inputs();
    check("R5 busy during start", reg_busy, 1);
    reg_done = 1; reg_start_sw = 1; step(); idle_inputs();
    check("R5 start while busy dropped", reg_busy, 0);
    inj_start_trig = 1; step(); idle_inputs();
    check("R5 trigger start", {inj_busy, reg_busy}, 2'b10);
    inj_done = 1; step(); idle_inputs();
    check("R5 completion clears busy", inj_busy, 0);
    reg_data_rd = 1; inj_data_rd = 1; step(); idle_inputs();
  endtask

  task automatic t_awd();
    awd_hi_set[2] = 1; step(); idle_inputs();
    check("R6 high source", {awd_flag, awd_hi_src}, {1'b1, 8'h04});
    awd_lo_set[5] = 1; step(); idle_inputs();
    check("R6 low source", awd_lo_src, 8'h20);
    clr_awd_hi[2] = 1; step(); idle_inputs();
    check("R6 summary holds with one source", {awd_flag, awd_hi_src}, {1'b1, 8'h00});
    clr_awd_lo[5] = 1; awd_lo_set[1] = 1; step(); idle_inputs();
    check("R6 set beats clear", awd_lo_src, 8'h02);
    clr_awd_lo = '1; step(); idle_inputs();
    check("R6 summary falls", awd_flag, 0);
  endtask

  task automatic t_clk_miss();
    chan_en = '1; chan_sync = '1; step();
    check("R7 sticky after enable", clk_miss_flag, 8'hFF);
    clr_clk_miss = '1; step(); idle_inputs();
    check("R7 cleared", clk_miss_flag, 8'h00);
    clk_miss_det[3] = 1; step(); idle_inputs();
    check("R7 detection", clk_miss_flag, 8'h08);
    clk_miss_det[3] = 1; clr_clk_miss[3] = 1; step(); idle_inputs();
    check("R7 detection beats clear", clk_miss_flag, 8'h08);
    clr_clk_miss[3] = 1; chan_sync[1] = 0; step(); idle_inputs();
    check("R7 unsynchronised forces", clk_miss_flag, 8'h02);
    clr_clk_miss[1] = 1; step(); idle_inputs();
    check("R7 clear ignored while unsynchronised", clk_miss_flag, 8'h02);
    chan_sync = '1; clr_clk_miss = '1; step(); idle_inputs();
  endtask

  task automatic t_short();
    short_det[4] = 1; step(); idle_inputs();
    check("R8 detection", short_flag, 8'h10);
    short_det[4] = 1; clr_short[4] = 1; step(); idle_inputs();
    check("R8 detection beats clear", short_flag, 8'h10);
    clr_short[4] = 1; step(); idle_inputs();
    check("R8 cleared", short_flag, 8'h00);
    chan_en[6] = 0; short_det[6] = 1; step(); idle_inputs();
    check("R8 disabled holds zero", short_flag, 8'h00);
    chan_en[6] = 1; short_det[0] = 1; step(); idle_inputs();
    chan_en[0] = 0; step();
    check("R8 disable clears", short_flag, 8'h00);
    chan_en = '1; clr_clk_miss = '1; step(); idle_inputs();
  endtask

  task automatic t_irq();
    irq_en = 7'b0000010; reg_done = 1; step(); idle_inputs();
    check("R9 irq lags flag", {reg_eoc, irq}, 2'b10);
    step();
    check("R9 irq raised", irq, 1);
    irq_en = '0; step();
    check("R9 masked", irq, 0);
    reg_data_rd = 1; step(); idle_inputs();
    irq_en = 7'b0100000; clk_miss_det[7] = 1; step(); idle_inputs();
    step();
    check("R9 clock-absent group", irq, 1);
    irq_en = 7'b1000000; step();
    check("R9 other group masked", irq, 0);
    irq_en = '0; clr_clk_miss = '1; step(); idle_inputs();
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs(); chan_en = '0; chan_sync = '0; irq_en = '0;
    @(negedge clk);
    t_reset();
    t_eoc();
    t_overrun();
    t_busy();
    t_awd();
    t_clk_miss();
    t_short();
    t_irq();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule